// File: doc/BRIEF.md
# Multi-channel sample vector serializer

This block turns a parallel vector of sample channels into a single stream one sample wide. It is meant for a downstream consumer that has only one data lane. One strobe marks each input vector. On that strobe the whole vector is copied into a holding register. The channels then leave one per clock cycle, lowest channel first, each with its own output strobe.

The producer must space its vectors so that each one has fully left before the next arrives. A new vector may land in the same cycle as the last element of the previous one, which gives gap-free back-to-back streaming. A vector that arrives earlier than that is a collision:
- the vector already in flight finishes unchanged;
- the new vector is discarded;
- the error output pulses for one cycle for each discarded vector.

The channel count and the sample width are parameters.

Top module: `vec_serializer`

## Requirements
- R1: A synchronous active-high reset drives `vout` and `err` low in the cycle after the reset edge and abandons any vector in flight, so no element of it is emitted after reset.
- R2: When a vector is accepted at clock edge t, `vout` is high in the CH cycles that follow. In the k-th of those cycles (k from 0) `dout` carries channel k, which is bits [k*DW +: DW] of `din` as sampled at edge t. Channel 0 is emitted first.
- R3: Once the last channel of a vector has been emitted and no new vector was accepted, `vout` is low.
- R4: A `vin` in the same cycle as the last element of the previous vector is accepted. Its channel 0 follows in the very next cycle with no gap, and `err` stays low.
- R5: A `vin` while a vector is in flight with elements still pending beyond the current one is a collision. `err` is high for exactly the one cycle after it. The in-flight vector completes with its original data. The colliding vector produces no output.
- R6: A `vin` while the block is idle is accepted without any error indication.
- R7: Changes on `din` after the accepting edge have no effect on the elements emitted for that vector.
- R8: The channel count CH (default 2) and the sample width DW (default 16) are parameters. A 3-channel, 8-bit instance serializes in order and flags collisions that arrive before its last element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | CH*DW | Channel vector, channel k in bits [k*DW +: DW] |
| vin | input | 1 | Vector strobe, one cycle per vector |
| dout | output | DW | Serialized sample |
| vout | output | 1 | Sample strobe for `dout` |
| err | output | 1 | One-cycle pulse per discarded colliding vector |

## Verification
A wrong element index shows up in the first cycle after acceptance as a channel emitted out of order, or as a burst of the wrong length one cycle later. A holding register that loads at the wrong time, such as on a colliding strobe, corrupts the remaining elements of the burst in the next cycle. The bench therefore compares every element of every burst against the vector it applied. An acceptance rule with an off-by-one error shows in the cycle after the boundary strobe: either a spurious `err` on a legal back-to-back vector, or a missing `err` together with a restarted burst on an early one.

// File: rtl/vec_serializer.sv
module vec_serializer #(
  parameter int CH = 2,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH*DW-1:0] din,
  input  logic             vin,
  output logic [DW-1:0]    dout,
  output logic             vout,
  output logic             err
);
  localparam int IW = (CH > 1) ? $clog2(CH) : 1;
  localparam logic [IW-1:0] LAST = IW'(CH - 1);

  logic [CH*DW-1:0] hold;
  logic [IW-1:0]    idx;
  logic             act;

  wire at_last = (idx == LAST);
  wire take    = vin && (!act || at_last);
  wire clash   = vin && act && !at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      idx <= '0;
      err <= 1'b0;
    end else begin
      err <= clash;
      if (take) begin
        act <= 1'b1;
        idx <= '0;
      end else if (act) begin
        if (at_last) act <= 1'b0;
        else         idx <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (take) hold <= din;

  assign vout = act;
  assign dout = hold[int'(idx)*DW +: DW];

  // R2
  first_elem_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vout) |-> idx == '0);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (vout && idx != LAST) |=> (vout && 32'(idx) == 32'($past(idx)) + 1));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(vin) && $past(vout)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (vout && idx != LAST) |=> $stable(hold));

  // R6
  idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (vin && !vout) |=> (vout && idx == '0 && !err));

  // R3
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (vout && idx == LAST && !vin) |=> !vout);
endmodule

// File: tb/test_vec_serializer.sv
module test_vec_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] din = '0;
  logic vin = 1'b0;
  logic [15:0] dout;
  logic vout, err;

  logic [23:0] din3 = '0;
  logic vin3 = 1'b0;
  logic [7:0] dout3;
  logic vout3, err3;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vec_serializer #(.CH(2), .DW(16)) i_vec_serializer (
    .clk(clk), .rst(rst), .din(din), .vin(vin),
    .dout(dout), .vout(vout), .err(err));

  vec_serializer #(.CH(3), .DW(8)) i_vec_serializer_w3 (
    .clk(clk), .rst(rst), .din(din3), .vin(vin3),
    .dout(dout3), .vout(vout3), .err(err3));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    chk("R1 vout after reset", 32'(vout), 0);
    chk("R1 err after reset", 32'(err), 0);
    rst = 1'b0;
  endtask

  task automatic t_single();
    din = {16'hB002, 16'hA001}; vin = 1'b1; tick();
    vin = 1'b0; din = 32'hFFFF_FFFF;
    chk("R6 err on idle accept", 32'(err), 0);
    chk("R2 vout ch0", 32'(vout), 1);
    chk("R2 dout ch0", 32'(dout), 32'hA001);
    chk("R7 din change ignored", 32'(dout), 32'hA001);
    tick();
    chk("R2 vout ch1", 32'(vout), 1);
    chk("R7 dout ch1 after din change", 32'(dout), 32'hB002);
    tick();
    chk("R3 vout idle after burst", 32'(vout), 0);
    chk("R3 err idle", 32'(err), 0);
  endtask

  task automatic t_back_to_back();
    din = {16'h2222, 16'h1111}; vin = 1'b1; tick();
    vin = 1'b0;
    chk("R2 b2b first ch0", 32'(dout), 32'h1111);
    tick();
    chk("R2 b2b first ch1", 32'(dout), 32'h2222);
    din = {16'h4444, 16'h3333}; vin = 1'b1; tick();
    vin = 1'b0;
    chk("R4 no gap vout", 32'(vout), 1);
    chk("R4 next ch0", 32'(dout), 32'h3333);
    chk("R4 no err", 32'(err), 0);
    tick();
    chk("R4 next ch1", 32'(dout), 32'h4444);
    chk("R4 no err later", 32'(err), 0);
    tick();
    chk("R3 idle after b2b", 32'(vout), 0);
  endtask

  task automatic t_collision();
    din = {16'h6666, 16'h5555}; vin = 1'b1; tick();
    chk("R2 coll ch0", 32'(dout), 32'h5555);
    din = {16'h8888, 16'h7777}; vin = 1'b1; tick();
    vin = 1'b0;
    chk("R5 err pulse", 32'(err), 1);
    chk("R5 in-flight ch1 kept", 32'(dout), 32'h6666);
    chk("R5 vout in-flight", 32'(vout), 1);
    tick();
    chk("R5 err one cycle", 32'(err), 0);
    chk("R5 dropped vector not emitted", 32'(vout), 0);
    tick();
    chk("R5 still idle", 32'(vout), 0);
  endtask

  task automatic t_reset_mid();
    din = {16'hDDDD, 16'hCCCC}; vin = 1'b1; tick();
    vin = 1'b0; rst = 1'b1; tick();
    rst = 1'b0;
    chk("R1 burst abandoned vout", 32'(vout), 0);
    tick();
    chk("R1 no leftover element", 32'(vout), 0);
  endtask

  task automatic t_three();
    din3 = {8'h33, 8'h22, 8'h11}; vin3 = 1'b1; tick();
    vin3 = 1'b0;
    chk("R8 ch0", 32'(dout3), 32'h11);
    tick();
    chk("R8 ch1", 32'(dout3), 32'h22);
    din3 = {8'h99, 8'h88, 8'h77}; vin3 = 1'b1; tick();
    chk("R8 err on early vin", 32'(err3), 1);
    chk("R8 ch2 kept", 32'(dout3), 32'h33);
    din3 = {8'h66, 8'h55, 8'h44}; vin3 = 1'b1; tick();
    vin3 = 1'b0;
    chk("R8 legal at last no err", 32'(err3), 0);
    chk("R8 new ch0", 32'(dout3), 32'h44);
    tick();
    chk("R8 new ch1", 32'(dout3), 32'h55);
    tick();
    chk("R8 new ch2", 32'(dout3), 32'h66);
    tick();
    chk("R8 idle", 32'(vout3), 0);
  endtask

  initial begin
    #5;
    t_reset();
    t_single();
    t_back_to_back();
    t_collision();
    t_reset_mid();
    t_three();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule